// File: doc/BRIEF.md
# OTP Region Lock Controller

This block holds the one-time-programmable byte space of a serial memory device and decides, for every program request, whether the write may land. The space is a small internal register array. It holds a control byte, a 16-byte serial-number area, two lock bytes, sixteen 16-byte general regions and two spare bytes. Every byte starts erased at 8'hFF. Programming can only clear bits: the stored byte becomes the old value ANDed with the new data.

Protection lives inside the space it protects. Clearing bit 0 of the control byte at 0x100 freezes the serial-number area. Clearing bit k of the lock byte at 0x112 freezes general region k+1, and bit k of 0x113 freezes region k+9. A lock bit can never return to 1, so a frozen region stays frozen. The lock bytes themselves remain programmable, and clearing further bits in them is how more regions get frozen. The bit in position 7 of the last spare byte (0x215) is fixed at 1. The command decoder in front of this block issues single-cycle requests that carry a byte address, data, and the state of the write-enable latch.

Top module: `otp_lock_ctrl`

## Requirements
- R1: After reset every byte in the valid range 0x100..0x215 reads 8'hFF, and `prog_done`, `prog_ok` and `rd_valid` are low.
- R2: A committed program request leaves the addressed byte equal to its previous value ANDed with `req_wdata`.
- R3: Every program request (`req_valid`=1, `req_write`=1) gives `prog_done`=1 on the cycle after it, and only then. Read requests and idle cycles give `prog_done`=0 on the following cycle.
- R4: A program request made while `wel`=0 is discarded and reports `prog_ok`=0.
- R5: While bit 0 of byte 0x100 is 0, program requests to the serial area 0x102..0x111 are discarded with `prog_ok`=0.
- R6: While bit k (k=0..7) of byte 0x112 is 0, general region k+1 (bytes 0x114+16k .. 0x123+16k) rejects programming. Bit k of byte 0x113 does the same for region k+9.
- R7: Lock bits can never go from 0 back to 1. A frozen region stays frozen. The bytes 0x100, 0x101, 0x112 and 0x113 are themselves never write-protected.
- R8: Bit 7 of byte 0x215 always reads 1. Its other bits program normally.
- R9: A program request with an address below 0x100 or above 0x215 is discarded with `prog_ok`=0. A read at such an address still pulses `rd_valid`, but its data is undefined.
- R10: A read request gives `rd_valid`=1 on the next cycle, with `rd_data` equal to the addressed byte.
- R11: Locking one general region does not affect programming of its neighbouring regions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = program, 0 = read |
| req_addr | input | 10 | OTP byte address |
| req_wdata | input | 8 | Program data (bits at 0 get cleared) |
| wel | input | 1 | Write-enable latch state |
| prog_done | output | 1 | One-cycle completion pulse for a program request |
| prog_ok | output | 1 | Qualifies `prog_done`: 1 = write committed |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |

## Verification
The bench drives the boundaries of the lock map. It programs the byte just past the end of a frozen region to catch an off-by-one region decode, and it programs region 16 (bit 7 of the second lock byte) to catch a bit-reversed lock index; either fault would let a write land that must be dropped. It tries to set a lock bit back to 1, which would silently unfreeze a region if the AND rule were missing. It also reads back 0x215 after writing zeros: a design that forgot the fixed bit would return 8'h00 instead of 8'h80. Writes without the write-enable latch and writes outside 0x100..0x215 must report failure; a design that skipped either gate would corrupt storage or alias an address onto a real byte.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;

  // Zones of the OTP byte space, in address order.
  typedef enum logic [2:0] {
    ZN_CTRL    = 3'd0,  // serial-lock control byte and its companion
    ZN_SERIAL  = 3'd1,  // serial-number area
    ZN_LOCKS   = 3'd2,  // general-region lock bytes
    ZN_GENERAL = 3'd3,  // general regions
    ZN_SPARE   = 3'd4,  // trailing spare bytes
    ZN_OUT     = 3'd5   // outside the valid range
  } zone_e;

  localparam logic [7:0] ERASED = 8'hFF;

endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode
  import otp_lock_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int BASE         = 'h100,
  parameter int CTRL_BYTES   = 2,
  parameter int SERIAL_BYTES = 16,
  parameter int GEN_REGIONS  = 16,
  parameter int REGION_BYTES = 16,
  parameter int SPARE_BYTES  = 2,
  localparam int LOCK_BYTES  = GEN_REGIONS / 8,
  localparam int DEPTH       = CTRL_BYTES + SERIAL_BYTES + LOCK_BYTES
                               + GEN_REGIONS * REGION_BYTES + SPARE_BYTES,
  localparam int IDX_W       = $clog2(DEPTH),
  localparam int REG_W       = $clog2(GEN_REGIONS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic [IDX_W-1:0]  idx,
  output zone_e             zone,
  output logic [REG_W-1:0]  region
);

  localparam int SER_START  = CTRL_BYTES;
  localparam int LOCK_START = SER_START + SERIAL_BYTES;
  localparam int GEN_START  = LOCK_START + LOCK_BYTES;
  localparam int SPR_START  = GEN_START + GEN_REGIONS * REGION_BYTES;
  localparam int RB_SH      = $clog2(REGION_BYTES);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + DEPTH - 1);
  localparam logic [IDX_W-1:0]  SER_I  = IDX_W'(SER_START);
  localparam logic [IDX_W-1:0]  LOCK_I = IDX_W'(LOCK_START);
  localparam logic [IDX_W-1:0]  GEN_I  = IDX_W'(GEN_START);
  localparam logic [IDX_W-1:0]  SPR_I  = IDX_W'(SPR_START);

  logic [ADDR_W-1:0] offset;
  logic [IDX_W-1:0]  gen_rel;

  always_comb begin
    in_range = (addr >= BASE_A) && (addr <= LAST_A);
    offset   = addr - BASE_A;
    idx      = offset[IDX_W-1:0];
    gen_rel  = idx - GEN_I;
    region   = gen_rel[RB_SH +: REG_W];
    if (!in_range)          zone = ZN_OUT;
    else if (idx < SER_I)   zone = ZN_CTRL;
    else if (idx < LOCK_I)  zone = ZN_SERIAL;
    else if (idx < GEN_I)   zone = ZN_LOCKS;
    else if (idx < SPR_I)   zone = ZN_GENERAL;
    else                    zone = ZN_SPARE;
  end

endmodule

// File: rtl/otp_lock_eval.sv
module otp_lock_eval
  import otp_lock_pkg::*;
#(
  parameter int GEN_REGIONS = 16,
  localparam int REG_W      = $clog2(GEN_REGIONS)
) (
  input  zone_e                  zone,
  input  logic [REG_W-1:0]       region,
  input  logic [7:0]             ser_ctrl,
  input  logic [GEN_REGIONS-1:0] gen_lock_bits,
  output logic                   locked
);

  // A lock bit is active once it has been programmed to 0.
  always_comb begin
    unique case (zone)
      ZN_SERIAL:  locked = ~ser_ctrl[0];
      ZN_GENERAL: locked = ~gen_lock_bits[region];
      default:    locked = 1'b0;
    endcase
  end

endmodule

// File: rtl/otp_store.sv
module otp_store #(
  parameter int DEPTH      = 278,
  parameter int LOCK_IDX   = 18,
  parameter int LOCK_BYTES = 2,
  parameter int FIXED_IDX  = 277,
  parameter logic [7:0] FIXED_MASK = 8'h80,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [7:0]              rd_q,
  output logic [7:0]              ser_ctrl,
  output logic [8*LOCK_BYTES-1:0] gen_lock_bits
);

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_d;

  // One byte per generate slot; the stuck bits of the fixed byte ignore data.
  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    localparam logic [7:0] KEEP = (i == FIXED_IDX) ? FIXED_MASK : 8'h00;
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic       hit;
    logic [7:0] nxt;
    always_comb begin
      hit = wr_en && (wr_idx == MY_IDX);
      nxt = mem[i] & (wr_data | KEEP);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[i] <= 8'hFF;
      else if (hit) mem[i] <= nxt;
    end
  end

  for (genvar j = 0; j < LOCK_BYTES; j++) begin : g_lock_tap
    assign gen_lock_bits[8*j +: 8] = mem[LOCK_IDX + j];
  end
  assign ser_ctrl = mem[0];

  always_comb rd_d = mem[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= 8'h00;
    else if (rd_en) rd_q <= rd_d;
  end

  // R7: once a lock bit is cleared it never comes back.
  a_r7_locks_never_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(gen_lock_bits)) & gen_lock_bits) == '0);
  a_r7_serial_lock_never_set: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ser_ctrl[0]) |-> !ser_ctrl[0]);
  // R8: the stuck bit survives every write.
  a_r8_fixed_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem[FIXED_IDX] & FIXED_MASK) == FIXED_MASK);

endmodule

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl
  import otp_lock_pkg::*;
#(
  parameter int ADDR_W       = 10,
  parameter int BASE         = 'h100,
  parameter int SERIAL_BYTES = 16,
  parameter int GEN_REGIONS  = 16,
  parameter int REGION_BYTES = 16,
  parameter int SPARE_BYTES  = 2,
  parameter logic [7:0] FIXED_MASK = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  input  logic              wel,
  output logic              prog_done,
  output logic              prog_ok,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  localparam int CTRL_BYTES = 2;
  localparam int LOCK_BYTES = GEN_REGIONS / 8;
  localparam int DEPTH      = CTRL_BYTES + SERIAL_BYTES + LOCK_BYTES
                              + GEN_REGIONS * REGION_BYTES + SPARE_BYTES;
  localparam int IDX_W      = $clog2(DEPTH);
  localparam int REG_W      = $clog2(GEN_REGIONS);
  localparam int LOCK_IDX   = CTRL_BYTES + SERIAL_BYTES;
  localparam int FIXED_IDX  = DEPTH - 1;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + DEPTH - 1);

  logic                  in_range;
  logic [IDX_W-1:0]      idx;
  zone_e                 zone;
  logic [REG_W-1:0]      region;
  logic                  locked;
  logic [7:0]            ser_ctrl;
  logic [GEN_REGIONS-1:0] gen_lock_bits;

  logic prog_req, rd_req, commit;
  logic done_d, ok_d, rdv_d;

  otp_addr_decode #(
    .ADDR_W(ADDR_W), .BASE(BASE), .CTRL_BYTES(CTRL_BYTES),
    .SERIAL_BYTES(SERIAL_BYTES), .GEN_REGIONS(GEN_REGIONS),
    .REGION_BYTES(REGION_BYTES), .SPARE_BYTES(SPARE_BYTES)
  ) u_dec (
    .addr(req_addr), .in_range(in_range), .idx(idx),
    .zone(zone), .region(region)
  );

  otp_lock_eval #(.GEN_REGIONS(GEN_REGIONS)) u_lock (
    .zone(zone), .region(region), .ser_ctrl(ser_ctrl),
    .gen_lock_bits(gen_lock_bits), .locked(locked)
  );

  otp_store #(
    .DEPTH(DEPTH), .LOCK_IDX(LOCK_IDX), .LOCK_BYTES(LOCK_BYTES),
    .FIXED_IDX(FIXED_IDX), .FIXED_MASK(FIXED_MASK)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit), .wr_idx(idx), .wr_data(req_wdata),
    .rd_en(rd_req && in_range), .rd_idx(idx), .rd_q(rd_data),
    .ser_ctrl(ser_ctrl), .gen_lock_bits(gen_lock_bits)
  );

  // Next-state logic for the response flags.
  always_comb begin
    prog_req = req_valid && req_write;
    rd_req   = req_valid && !req_write;
    commit   = prog_req && wel && in_range && !locked;
    done_d   = prog_req;
    ok_d     = commit;
    rdv_d    = rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_done <= 1'b0;
      prog_ok   <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      prog_done <= done_d;
      prog_ok   <= ok_d;
      rd_valid  <= rdv_d;
    end
  end

  a_r3_done_follows_prog: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> prog_done);
  a_r3_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write) |=> !prog_done);
  a_r4_wel_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !wel) |=> !prog_ok);
  a_r9_range_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && ((req_addr < BASE_A) || (req_addr > LAST_A)))
      |=> !prog_ok);
  a_r5_serial_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && zone == ZN_SERIAL && !ser_ctrl[0]) |=> !prog_ok);
  a_r6_region_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && zone == ZN_GENERAL && !gen_lock_bits[region])
      |=> !prog_ok);
  a_r10_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  a_r3_ok_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |-> prog_done);

endmodule

// File: tb/otp_lock_ctrl_test.sv
module otp_lock_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write, wel;
  logic [9:0] req_addr;
  logic [7:0] req_wdata;
  logic       prog_done, prog_ok, rd_valid;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  otp_lock_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wel(wel),
    .prog_done(prog_done), .prog_ok(prog_ok), .rd_valid(rd_valid),
    .rd_data(rd_data)
  );

  // {tag[3:0], wr, wel, addr[9:0], data[7:0], exp_ok, exp_rd[7:0], chk_rd}
  localparam int NV = 31;
  localparam logic [33:0] VEC [NV] = '{
    {4'd1,  1'b0, 1'b1, 10'h102, 8'h00, 1'b0, 8'hFF, 1'b1}, // R1 erased
    {4'd2,  1'b1, 1'b1, 10'h102, 8'hA5, 1'b1, 8'h00, 1'b0}, // R2
    {4'd2,  1'b0, 1'b1, 10'h102, 8'h00, 1'b0, 8'hA5, 1'b1},
    {4'd2,  1'b1, 1'b1, 10'h102, 8'h0F, 1'b1, 8'h00, 1'b0}, // R2 AND
    {4'd2,  1'b0, 1'b1, 10'h102, 8'h00, 1'b0, 8'h05, 1'b1},
    {4'd4,  1'b1, 1'b0, 10'h103, 8'h00, 1'b0, 8'h00, 1'b0}, // R4 no wel
    {4'd4,  1'b0, 1'b0, 10'h103, 8'h00, 1'b0, 8'hFF, 1'b1},
    {4'd8,  1'b1, 1'b1, 10'h215, 8'h00, 1'b1, 8'h00, 1'b0}, // R8
    {4'd8,  1'b0, 1'b1, 10'h215, 8'h00, 1'b0, 8'h80, 1'b1},
    {4'd9,  1'b1, 1'b1, 10'h0FF, 8'h00, 1'b0, 8'h00, 1'b0}, // R9 below
    {4'd9,  1'b0, 1'b1, 10'h0FF, 8'h00, 1'b0, 8'h00, 1'b0},
    {4'd9,  1'b1, 1'b1, 10'h216, 8'h00, 1'b0, 8'h00, 1'b0}, // R9 above
    {4'd6,  1'b1, 1'b1, 10'h114, 8'h3C, 1'b1, 8'h00, 1'b0}, // R6 region 1
    {4'd6,  1'b1, 1'b1, 10'h112, 8'hFE, 1'b1, 8'h00, 1'b0}, // lock region 1
    {4'd6,  1'b1, 1'b1, 10'h114, 8'h00, 1'b0, 8'h00, 1'b0},
    {4'd6,  1'b0, 1'b1, 10'h114, 8'h00, 1'b0, 8'h3C, 1'b1},
    {4'd11, 1'b1, 1'b1, 10'h124, 8'h55, 1'b1, 8'h00, 1'b0}, // R11 region 2
    {4'd11, 1'b0, 1'b1, 10'h124, 8'h00, 1'b0, 8'h55, 1'b1},
    {4'd6,  1'b1, 1'b1, 10'h113, 8'h7F, 1'b1, 8'h00, 1'b0}, // lock region 16
    {4'd6,  1'b1, 1'b1, 10'h20F, 8'h00, 1'b0, 8'h00, 1'b0},
    {4'd6,  1'b0, 1'b1, 10'h20F, 8'h00, 1'b0, 8'hFF, 1'b1},
    {4'd11, 1'b1, 1'b1, 10'h203, 8'h00, 1'b1, 8'h00, 1'b0}, // R11 region 15
    {4'd11, 1'b0, 1'b1, 10'h203, 8'h00, 1'b0, 8'h00, 1'b1},
    {4'd5,  1'b1, 1'b1, 10'h100, 8'hFE, 1'b1, 8'h00, 1'b0}, // R5 lock serial
    {4'd5,  1'b1, 1'b1, 10'h111, 8'h00, 1'b0, 8'h00, 1'b0},
    {4'd5,  1'b0, 1'b1, 10'h111, 8'h00, 1'b0, 8'hFF, 1'b1},
    {4'd7,  1'b1, 1'b1, 10'h112, 8'hFF, 1'b1, 8'h00, 1'b0}, // R7 no unlock
    {4'd7,  1'b0, 1'b1, 10'h112, 8'h00, 1'b0, 8'hFE, 1'b1},
    {4'd7,  1'b1, 1'b1, 10'h114, 8'h00, 1'b0, 8'h00, 1'b0},
    {4'd7,  1'b1, 1'b1, 10'h101, 8'h00, 1'b1, 8'h00, 1'b0},
    {4'd7,  1'b0, 1'b1, 10'h100, 8'h00, 1'b0, 8'hFE, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; wel = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: outputs quiet after reset
    @(negedge clk);
    chk("R1 prog_done", {7'd0, prog_done}, 8'h00);
    chk("R1 prog_ok",   {7'd0, prog_ok},   8'h00);
    chk("R1 rd_valid",  {7'd0, rd_valid},  8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[33:30], i);
      @(negedge clk);
      req_valid = 1'b1; req_write = v[29]; wel = v[28];
      req_addr = v[27:18]; req_wdata = v[17:10];
      @(posedge clk); #1;
      if (v[29]) begin
        chk({tag, " done"}, {7'd0, prog_done}, 8'h01);
        chk({tag, " ok"},   {7'd0, prog_ok},   {7'd0, v[9]});
      end else begin
        chk({tag, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
        if (v[0]) chk({tag, " rd_data"}, rd_data, v[8:1]);
      end
    end

    // R3: done is a single pulse and reads never raise it
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; wel = 1'b1; req_addr = 10'h130; req_wdata = 8'hF0;
    @(negedge clk); idle();
    @(posedge clk); #1;
    chk("R3 single pulse", {7'd0, prog_done}, 8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 10'h130;
    @(posedge clk); #1;
    chk("R3 no done on read", {7'd0, prog_done}, 8'h00);
    chk("R10 read after R3 write", rd_data, 8'hF0);
    @(negedge clk); idle();
    @(posedge clk); #1;
    chk("R10 rd_valid drops", {7'd0, rd_valid}, 8'h00);

    finish_run();
  end

endmodule